// File: doc/BRIEF.md
# Ethernet MAC Line Control Unit

This unit holds the line control word of a 10 Mb/s Ethernet MAC and turns its fields into the signals the rest of the MAC consumes. A host reaches the word through a simple register port: one address, a write strobe, and a read strobe whose data comes back one cycle later. The six lowest bits always read as a fixed identifier and cannot be written.

The receive and transmit enable fields do not act on the datapaths directly. Each one passes through a gate that is frozen while the matching packet-activity strobe is high. A frame that is already in flight therefore finishes, and the new setting applies from the next packet boundary. The unit also picks the physical interface: twisted pair, the attachment-unit port, or an automatic choice that follows a link-good input. It allows the twisted-pair transmitter to run only when link pulses are seen or a link-test override is asserted. A detected wakeup frame can raise a held wakeup pin, and optionally an interrupt request. Three mode bits for backoff, deferral and polarity correction are passed straight out to the datapaths that use them.

Top module: `eth_linectl`

## Requirements
- R1: While reset is high and on the first cycle after it, every writable bit is 0. As a result rx_enable, tx_enable, tp_tx_active, wake_pin, wake_irq and the three mode outputs are 0, and phy_sel is 2'b01 (twisted pair).
- R2: A read with reg_addr equal to REG_OFFSET (default 12'h112) returns, on the cycle after rd_en, the stored bits 15:6 above the constant 6'b010011 in bits 5:0. Writes never change bits 5:0. Any other read returns 0.
- R3: A write takes effect only when reg_addr equals REG_OFFSET. A write to any other address changes nothing.
- R4: While rx_busy is high, rx_enable holds its value. On any cycle where rx_busy is low, rx_enable takes bit 6 of the stored word on the next edge. Clearing bit 6 during a frame therefore lets that frame finish.
- R5: The same rule applies to tx_enable, which is driven from bit 7 and frozen by tx_busy.
- R6: phy_sel is registered and uses one-hot codes: 2'b01 means twisted pair and 2'b10 means the attachment-unit port. Bit 8 set selects the port whatever bit 9 holds. Bits 8 and 9 both 0 select twisted pair. Bit 8 = 0 with bit 9 = 1 is auto mode, which selects twisted pair while link_good is high and the port otherwise.
- R7: tp_tx_active is high on the cycle after the twisted-pair interface is selected and either link_good or link_test_off is high. Otherwise it is low.
- R8: While bit 15 is 0, wake_frame has no effect. While bit 15 is 1, a wake_frame pulse sets wake_pin on the next edge. The pin stays high until a write that lands clears bit 15.
- R9: wake_irq is set together with wake_pin only when bit 10 is also 1. It is cleared by the same kind of write and is never high while wake_pin is low.
- R10: If a write that clears bit 15 and a wake_frame arrive in the same cycle, the clear wins and both wake outputs are 0 on the next cycle.
- R11: mod_backoff, defer2_dis and pol_corr_dis follow bits 11, 13 and 12 of the stored word. Each changes on the cycle after the write that sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register port address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, one cycle after rd_en |
| rx_busy | input | 1 | A receive frame is in progress |
| tx_busy | input | 1 | A transmit frame is in progress |
| link_good | input | 1 | Link pulses are detected on twisted pair |
| link_test_off | input | 1 | Link-test override |
| wake_frame | input | 1 | Pulse when a wakeup frame is detected |
| rx_enable | output | 1 | Receiver enable, applied at a packet boundary |
| tx_enable | output | 1 | Transmitter enable, applied at a packet boundary |
| phy_sel | output | 2 | Selected interface (01 twisted pair, 10 port) |
| tp_tx_active | output | 1 | Twisted-pair transmitter allowed |
| wake_pin | output | 1 | Held wakeup pin |
| wake_irq | output | 1 | Wakeup interrupt request |
| mod_backoff | output | 1 | Modified backoff mode |
| defer2_dis | output | 1 | Two-part deferral disabled |
| pol_corr_dis | output | 1 | Receive polarity correction disabled |

## Verification
Two events can fall on the same edge: a host write that clears the wakeup-enable bit, and a wake_frame pulse. The bench forces both together in a directed step, expects both wake outputs to be low afterwards, and checks that a later frame stays ignored. A host write that clears an enable bit can also land while the matching busy strobe is high. The bench provokes this and expects the enable output to hold until the strobe falls. A behavioural reference model is compared with every output on each clock, through directed phases and a long random phase.

// File: rtl/eth_linectl_pkg.sv
package eth_linectl_pkg;
  localparam int CTL_W = 16;
  localparam int ID_W  = 6;
  localparam logic [ID_W-1:0] CTL_ID = 6'b010011;

  localparam int B_RX_ON    = 6;
  localparam int B_TX_ON    = 7;
  localparam int B_AUI_ONLY = 8;
  localparam int B_AUTO_SEL = 9;
  localparam int B_WAKE_IRQ = 10;
  localparam int B_MOD_BO   = 11;
  localparam int B_POL_DIS  = 12;
  localparam int B_DEF_DIS  = 13;
  localparam int B_WAKE_EN  = 15;

  typedef enum logic [1:0] {
    PHY_TP  = 2'b01,
    PHY_AUI = 2'b10
  } phy_sel_e;
endpackage

// File: rtl/linectl_reg.sv
module linectl_reg
  import eth_linectl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h112
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [CTL_W-1:0]  rd_data,
  output logic [CTL_W-1:0]  ctl,
  output logic              wake_clr
);
  logic               hit;
  logic [CTL_W-1:ID_W] bits_q;

  assign hit      = (reg_addr == REG_OFFSET);
  assign ctl      = {bits_q, CTL_ID};
  assign wake_clr = wr_en && hit && !wr_data[B_WAKE_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en && hit) bits_q <= wr_data[CTL_W-1:ID_W];
      rd_data <= (rd_en && hit) ? ctl : '0;
    end
  end
endmodule

// File: rtl/linectl_gate.sv
module linectl_gate (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic req,
  output logic en
);
  always_ff @(posedge clk) begin
    if (rst)       en <= 1'b0;
    else if (!busy) en <= req;
  end
endmodule

// File: rtl/linectl_phy.sv
module linectl_phy
  import eth_linectl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       aui_only,
  input  logic       auto_sel,
  input  logic       link_good,
  input  logic       link_test_off,
  output logic [1:0] phy_sel,
  output logic       tp_tx_active
);
  logic use_tp;

  assign use_tp = !aui_only && (!auto_sel || link_good);

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_sel      <= PHY_TP;
      tp_tx_active <= 1'b0;
    end else begin
      phy_sel      <= use_tp ? PHY_TP : PHY_AUI;
      tp_tx_active <= use_tp && (link_good || link_test_off);
    end
  end
endmodule

// File: rtl/linectl_wake.sv
module linectl_wake (
  input  logic clk,
  input  logic rst,
  input  logic wake_en,
  input  logic route_irq,
  input  logic wake_frame,
  input  logic clr,
  output logic pin,
  output logic irq
);
  logic fire;

  assign fire = wake_frame && wake_en;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pin <= 1'b0;
      irq <= 1'b0;
    end else if (fire) begin
      pin <= 1'b1;
      if (route_irq) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/eth_linectl.sv
module eth_linectl
  import eth_linectl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h112
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  output logic [15:0]       rd_data,
  input  logic              rx_busy,
  input  logic              tx_busy,
  input  logic              link_good,
  input  logic              link_test_off,
  input  logic              wake_frame,
  output logic              rx_enable,
  output logic              tx_enable,
  output logic [1:0]        phy_sel,
  output logic              tp_tx_active,
  output logic              wake_pin,
  output logic              wake_irq,
  output logic              mod_backoff,
  output logic              defer2_dis,
  output logic              pol_corr_dis
);
  localparam int NDIR = 2;

  logic [CTL_W-1:0] ctl;
  logic             wake_clr;
  logic [NDIR-1:0]  dir_busy, dir_req, dir_en;

  linectl_reg #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_reg (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ctl(ctl), .wake_clr(wake_clr)
  );

  assign dir_busy = {tx_busy, rx_busy};
  assign dir_req  = {ctl[B_TX_ON], ctl[B_RX_ON]};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    linectl_gate u_gate (
      .clk(clk), .rst(rst), .busy(dir_busy[g]), .req(dir_req[g]), .en(dir_en[g])
    );
  end

  assign rx_enable = dir_en[0];
  assign tx_enable = dir_en[1];

  linectl_phy u_phy (
    .clk(clk), .rst(rst), .aui_only(ctl[B_AUI_ONLY]), .auto_sel(ctl[B_AUTO_SEL]),
    .link_good(link_good), .link_test_off(link_test_off),
    .phy_sel(phy_sel), .tp_tx_active(tp_tx_active)
  );

  linectl_wake u_wake (
    .clk(clk), .rst(rst), .wake_en(ctl[B_WAKE_EN]), .route_irq(ctl[B_WAKE_IRQ]),
    .wake_frame(wake_frame), .clr(wake_clr), .pin(wake_pin), .irq(wake_irq)
  );

  assign mod_backoff  = ctl[B_MOD_BO];
  assign defer2_dis   = ctl[B_DEF_DIS];
  assign pol_corr_dis = ctl[B_POL_DIS];
endmodule

// File: rtl/linectl_chk.sv
module linectl_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h112
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wr_en,
  input logic [15:0]       wr_data,
  input logic              rd_en,
  input logic [15:0]       rd_data,
  input logic              rx_busy,
  input logic              tx_busy,
  input logic              rx_enable,
  input logic              tx_enable,
  input logic [1:0]        phy_sel,
  input logic              tp_tx_active,
  input logic              wake_pin,
  input logic              wake_irq
);
  // R2
  id_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_addr == REG_OFFSET) |=> rd_data[5:0] == 6'b010011);
  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rx_busy |=> $stable(rx_enable));
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> $stable(tx_enable));
  // R6
  sel_code_chk: assert property (@(posedge clk) disable iff (rst)
    (phy_sel == 2'b01) || (phy_sel == 2'b10));
  // R7
  tp_sel_chk: assert property (@(posedge clk) disable iff (rst)
    tp_tx_active |-> phy_sel == 2'b01);
  // R9
  irq_pin_chk: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> wake_pin);
  // R8
  pin_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_pin) |-> $past(wr_en && reg_addr == REG_OFFSET && !wr_data[15]));
endmodule

bind eth_linectl linectl_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (.*);

// File: tb/eth_linectl_test.sv
module eth_linectl_test;
  localparam logic [11:0] OFF = 12'h112;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] reg_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rx_busy = 1'b0, tx_busy = 1'b0, link_good = 1'b0;
  logic        link_test_off = 1'b0, wake_frame = 1'b0;
  logic [15:0] rd_data;
  logic        rx_enable, tx_enable, tp_tx_active, wake_pin, wake_irq;
  logic        mod_backoff, defer2_dis, pol_corr_dis;
  logic [1:0]  phy_sel;

  int checks = 0, errors = 0, cyc = 0;

  eth_linectl uut (.*);

  always #5 clk = ~clk;

  // reference model state
  logic [15:0] m_ctl, m_rd;
  logic        m_rx, m_tx, m_tp, m_pin, m_irq;
  logic [1:0]  m_sel;

  always @(posedge clk) begin
    bit hit, tp, clr;
    if (rst) begin
      m_ctl <= 16'h0013; m_rd <= '0; m_rx <= 0; m_tx <= 0;
      m_sel <= 2'b01; m_tp <= 0; m_pin <= 0; m_irq <= 0;
    end else begin
      hit = (reg_addr == OFF);
      if (!rx_busy) m_rx <= m_ctl[6];
      if (!tx_busy) m_tx <= m_ctl[7];
      if (m_ctl[8])      tp = 0;
      else if (m_ctl[9]) tp = link_good;
      else               tp = 1;
      m_sel <= tp ? 2'b01 : 2'b10;
      m_tp  <= tp && (link_good || link_test_off);
      clr = wr_en && hit && !wr_data[15];
      if (clr) begin m_pin <= 0; m_irq <= 0; end
      else if (wake_frame && m_ctl[15]) begin
        m_pin <= 1;
        if (m_ctl[10]) m_irq <= 1;
      end
      m_rd <= (rd_en && hit) ? m_ctl : 16'h0;
      if (wr_en && hit) m_ctl <= {wr_data[15:6], 6'b010011};
    end
  end

  task automatic cmp(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  bit model_on = 0;
  always @(negedge clk) begin
    if (model_on && !rst) begin
      cmp("R2/R3 rd_data", rd_data, m_rd);
      cmp("R4 rx_enable", rx_enable, m_rx);
      cmp("R5 tx_enable", tx_enable, m_tx);
      cmp("R6 phy_sel", phy_sel, m_sel);
      cmp("R7 tp_tx_active", tp_tx_active, m_tp);
      cmp("R8 wake_pin", wake_pin, m_pin);
      cmp("R9 wake_irq", wake_irq, m_irq);
      cmp("R11 mod_backoff", mod_backoff, m_ctl[11]);
      cmp("R11 defer2_dis", defer2_dis, m_ctl[13]);
      cmp("R11 pol_corr_dis", pol_corr_dis, m_ctl[12]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic write(logic [11:0] a, logic [15:0] d);
    reg_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic read_exp(string req, logic [15:0] exp);
    reg_addr = OFF; rd_en = 1;
    @(negedge clk); rd_en = 0;
    cmp(req, rd_data, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    cmp("R1 rx_enable", rx_enable, 0);
    cmp("R1 tx_enable", tx_enable, 0);
    cmp("R1 phy_sel", phy_sel, 2'b01);
    cmp("R1 tp_tx_active", tp_tx_active, 0);
    cmp("R1 wake_pin", wake_pin, 0);
    cmp("R1 mode bits", {mod_backoff, defer2_dis, pol_corr_dis}, 0);
    model_on = 1;
    read_exp("R1 R2 reset readback", 16'h0013);

    // R2 low bits read-only
    write(OFF, 16'h002C);
    read_exp("R2 id bits fixed", 16'h0013);
    // R3 wrong address ignored
    write(12'h110, 16'hFFC0);
    read_exp("R3 wrong address", 16'h0013);

    // R4 receive enable at boundaries
    write(OFF, 16'h0040);
    idle(1);
    cmp("R4 rx on when idle", rx_enable, 1);
    rx_busy = 1; idle(1);
    write(OFF, 16'h0000);
    idle(3);
    cmp("R4 rx held during frame", rx_enable, 1);
    rx_busy = 0; idle(1);
    cmp("R4 rx off after frame", rx_enable, 0);

    // R5 transmit enable
    tx_busy = 1;
    write(OFF, 16'h0080);
    idle(2);
    cmp("R5 tx held off during frame", tx_enable, 0);
    tx_busy = 0; idle(1);
    cmp("R5 tx on after frame", tx_enable, 1);

    // R6 R7 interface select
    link_good = 0; write(OFF, 16'h0200); idle(1);
    cmp("R6 auto no link", phy_sel, 2'b10);
    link_good = 1; idle(1);
    cmp("R6 auto link", phy_sel, 2'b01);
    cmp("R7 tp active on link", tp_tx_active, 1);
    write(OFF, 16'h0300); idle(1);
    cmp("R6 port forced", phy_sel, 2'b10);
    link_good = 0; write(OFF, 16'h0000); idle(1);
    cmp("R7 tp idle without link", tp_tx_active, 0);
    link_test_off = 1; idle(1);
    cmp("R7 override", tp_tx_active, 1);
    link_test_off = 0;

    // R8 ignored when disabled
    wake_frame = 1; idle(1); wake_frame = 0; idle(1);
    cmp("R8 wake ignored", wake_pin, 0);
    write(OFF, 16'h8000);
    wake_frame = 1; idle(1); wake_frame = 0; idle(1);
    cmp("R8 pin set", wake_pin, 1);
    cmp("R9 no irq route", wake_irq, 0);
    write(OFF, 16'h8400);
    wake_frame = 1; idle(1); wake_frame = 0;
    cmp("R9 irq set", wake_irq, 1);
    // R10 clearing write collides with frame
    wake_frame = 1; write(OFF, 16'h0400); wake_frame = 0;
    cmp("R10 clear wins pin", wake_pin, 0);
    cmp("R10 clear wins irq", wake_irq, 0);
    wake_frame = 1; idle(1); wake_frame = 0; idle(1);
    cmp("R10 stays clear", wake_pin, 0);

    // R11 mode bits
    write(OFF, 16'h3800);
    cmp("R11 modes", {mod_backoff, defer2_dis, pol_corr_dis}, 3'b111);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      rx_busy       = ($urandom % 4) != 0 ? rx_busy : ~rx_busy;
      tx_busy       = ($urandom % 4) != 0 ? tx_busy : ~tx_busy;
      link_good     = $urandom % 2;
      link_test_off = ($urandom % 5) == 0;
      wake_frame    = ($urandom % 6) == 0;
      rd_en         = ($urandom % 3) == 0;
      wr_en         = ($urandom % 6) == 0;
      reg_addr      = ($urandom % 4) != 0 ? OFF : 12'($urandom);
      wr_data       = 16'($urandom);
      @(negedge clk);
    end
    wr_en = 0; rd_en = 0; wake_frame = 0;
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule